// File: doc/BRIEF.md
# Full-Frame Pixel Write Sweeper

This block is the bus master for a square frame store of 256 by 256 pixels. When an operator releases a start button, it walks every pixel position and issues one write per pixel on a request/ready bus. Each write carries a column address, a row address and a pixel word built from those two coordinates. The target paces the transfers: a pixel counts as written only in a cycle where the target raises ready while the request is up. Until then, the address and the data stay where they are.

A sweep runs in raster order. The column moves first, and the row steps when the column wraps. Once the bottom-right pixel is taken, the request and the write select drop, both coordinates return to zero, and the block waits for the next press-and-release. Pressing the button does nothing until it is let go. Button activity during a sweep is ignored. The button input is expected to be debounced already.

Top module: `fb_sweep_initiator`

## Requirements
- R1: While the synchronous active-high reset is sampled high, and in the first cycle after it, the request and write select are low and both coordinates are 0.
- R2: While the start button is held down, the request stays low.
- R3: When the button is sampled low after having been sampled high while idle, the request is high from the next cycle on.
- R4: The write select is high in every cycle in which the request is high (a write), and low whenever the request is low.
- R5: A cycle with request high and ready low leaves the column, the row and the pixel word unchanged in the next cycle.
- R6: Each accepted transfer (request and ready both high) moves to the next pixel in raster order. The column increments. From 255 it wraps to 0 and the row increments.
- R7: The pixel word equals {column, row, column XOR row}: the column in bits 23:16, the row in bits 15:8, and the XOR in bits 7:0.
- R8: In the cycle after the transfer at column 255, row 255 is accepted, the request and write select are low and both coordinates are 0. The block then stays idle until a new press and release.
- R9: A press and release of the button during a sweep neither stops nor restarts the sweep.
- R10: A reset asserted in the middle of a sweep aborts it. The block then behaves as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startBtn | input | 1 | Debounced start button, high while pressed |
| busReady | input | 1 | Target accepts the current transfer |
| busReq | output | 1 | Transfer request strobe |
| busWrite | output | 1 | High for a write, low for a read |
| busCol | output | 8 | Column address |
| busRow | output | 8 | Row address |
| busWrData | output | 24 | Pixel word for the current address |

## Verification
Two events can fall in the same cycle: a transfer being accepted and a button edge arriving, or a wait state being inserted at a column wrap. The bench presses and releases the button while a sweep runs under random ready, so that button edges land on accepted cycles and on stalled cycles alike. It also forces a run of ready-low cycles partway through the sweep. A behavioural model that ignores the button during a sweep is compared with the outputs on every clock, and explicit checks confirm that the request never drops early and that the held address does not move.

// File: rtl/fb_sweep_pkg.sv
package fb_sweep_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SWEEP = 2'd2
  } sweepState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAddr;
    logic advAddr;
  } dpCtrl_t;

endpackage

// File: rtl/fb_sweep_datapath.sv
module fb_sweep_datapath
  import fb_sweep_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  dpCtrl_t                dpCtrl,
  output logic [COORD_W-1:0]     colAddr,
  output logic [COORD_W-1:0]     rowAddr,
  output logic [3*COORD_W-1:0]   pixWord,
  output logic                   lastPixel
);

  localparam logic [COORD_W-1:0] MAX_COORD = {COORD_W{1'b1}};

  logic colAtEnd;

  assign colAtEnd  = (colAddr == MAX_COORD);
  assign lastPixel = colAtEnd && (rowAddr == MAX_COORD);

  // raster counters: column is the fast axis
  always_ff @(posedge clk) begin
    if (rst || dpCtrl.clrAddr) begin
      colAddr <= '0;
      rowAddr <= '0;
    end else if (dpCtrl.advAddr) begin
      if (colAtEnd) begin
        colAddr <= '0;
        rowAddr <= rowAddr + 1'b1;
      end else begin
        colAddr <= colAddr + 1'b1;
      end
    end
  end

  // per-pixel source derived from the coordinates
  assign pixWord = {colAddr, rowAddr, colAddr ^ rowAddr};

  p_row_step_r6: assert property (@(posedge clk) disable iff (rst)
    (dpCtrl.advAddr && colAtEnd && !lastPixel) |=>
      (colAddr == '0) && (rowAddr == COORD_W'($past(rowAddr) + 1'b1)));

endmodule

// File: rtl/fb_sweep_ctrl.sv
module fb_sweep_ctrl
  import fb_sweep_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    startBtn,
  input  logic    busReady,
  input  logic    lastPixel,
  output logic    busReq,
  output logic    busWrite,
  output dpCtrl_t dpCtrl
);

  sweepState_t state, stateNext;
  logic        accepted;

  assign busReq   = (state == ST_SWEEP);
  assign busWrite = (state == ST_SWEEP);
  assign accepted = busReq && busReady;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (startBtn) stateNext = ST_ARMED;
      ST_ARMED: if (!startBtn) stateNext = ST_SWEEP;
      ST_SWEEP: if (accepted && lastPixel) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    dpCtrl.advAddr = accepted;
    dpCtrl.clrAddr = accepted && lastPixel;
  end

  p_held_no_req_r2: assert property (@(posedge clk) disable iff (rst)
    (!busReq && startBtn) |=> !busReq);

  p_start_on_release_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && !startBtn) |=> busReq);

  p_button_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busReq && !(busReady && lastPixel)) |=> busReq);

endmodule

// File: rtl/fb_sweep_initiator.sv
module fb_sweep_initiator
  import fb_sweep_pkg::*;
#(
  parameter int COORD_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 startBtn,
  input  logic                 busReady,
  output logic                 busReq,
  output logic                 busWrite,
  output logic [COORD_W-1:0]   busCol,
  output logic [COORD_W-1:0]   busRow,
  output logic [3*COORD_W-1:0] busWrData
);

  localparam logic [COORD_W-1:0] MAX_COORD = {COORD_W{1'b1}};

  dpCtrl_t dpCtrl;
  logic    lastPixel;

  fb_sweep_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .startBtn (startBtn),
    .busReady (busReady),
    .lastPixel(lastPixel),
    .busReq   (busReq),
    .busWrite (busWrite),
    .dpCtrl   (dpCtrl)
  );

  fb_sweep_datapath #(.COORD_W(COORD_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .dpCtrl   (dpCtrl),
    .colAddr  (busCol),
    .rowAddr  (busRow),
    .pixWord  (busWrData),
    .lastPixel(lastPixel)
  );

  p_hold_on_wait_r5: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busReady) |=>
      ($stable(busCol) && $stable(busRow) && $stable(busWrData)));

  p_col_step_r6: assert property (@(posedge clk) disable iff (rst)
    (busReq && busReady && busCol != MAX_COORD) |=>
      (busCol == COORD_W'($past(busCol) + 1'b1)) && $stable(busRow));

  p_frame_end_r8: assert property (@(posedge clk) disable iff (rst)
    (busReq && busReady && busCol == MAX_COORD && busRow == MAX_COORD) |=>
      (!busReq && !busWrite && busCol == '0 && busRow == '0));

endmodule

// File: tb/fb_sweep_initiator_bench.sv
module fb_sweep_initiator_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startBtn = 1'b0;
  logic        busReady = 1'b0;
  logic        busReq, busWrite;
  logic [7:0]  busCol, busRow;
  logic [23:0] busWrData;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit stall   = 1'b0;
  bit started = 1'b0;
  bit done    = 1'b0;

  // behavioural reference: phase 0 idle, 1 button held, 2 sweeping
  int refPh  = 0;
  int refCol = 0;
  int refRow = 0;

  always #10 clk = ~clk;  // 50 MHz

  fb_sweep_initiator u_fb_sweep_initiator (
    .clk(clk), .rst(rst), .startBtn(startBtn), .busReady(busReady),
    .busReq(busReq), .busWrite(busWrite), .busCol(busCol),
    .busRow(busRow), .busWrData(busWrData)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    started = 1'b1;
    if (rst) begin
      refPh = 0; refCol = 0; refRow = 0;
    end else begin
      case (refPh)
        0: if (startBtn) refPh = 1;
        1: if (!startBtn) refPh = 2;
        default: if (busReady) begin
          if (refCol == 255 && refRow == 255) begin
            refCol = 0; refRow = 0; refPh = 0;
          end else if (refCol == 255) begin
            refCol = 0; refRow = refRow + 1;
          end else begin
            refCol = refCol + 1;
          end
        end
      endcase
    end
  end

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (started && !done) begin
      int expData;
      expData = (refCol << 16) | (refRow << 8) | (refCol ^ refRow);
      check(busReq == (refPh == 2), "R3 request", busReq, refPh == 2);
      check(busWrite == (refPh == 2), "R4 write select", busWrite, refPh == 2);
      check(busCol == refCol && busRow == refRow, "R6 address",
            {busRow, busCol}, (refRow << 8) | refCol);
      check(busWrData == expData, "R7 pixel word", busWrData, expData);
    end
  end

  // target model: random ready latency
  always @(negedge clk) busReady <= stall ? 1'b0 : (($urandom % 4) != 0);

  // watchdog
  initial begin
    wait (cycles > 190000);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  hc, hr;
    logic [23:0] hd;
    repeat (3) @(negedge clk);
    check(!busReq && !busWrite && busCol == 0 && busRow == 0, "R1 in reset",
          {busReq, busWrite, busCol, busRow}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!busReq && !busWrite && busCol == 0 && busRow == 0, "R1 after reset",
          {busReq, busWrite, busCol, busRow}, 0);

    // hold the button: nothing starts
    startBtn = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!busReq, "R2 held button", busReq, 0);
    end
    startBtn = 1'b0;
    @(negedge clk);
    check(busReq && busWrite, "R3 start on release", {busReq, busWrite}, 2'b11);

    repeat (300) @(negedge clk);

    // forced wait states
    stall = 1'b1;
    @(negedge clk);
    hc = busCol; hr = busRow; hd = busWrData;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(busCol == hc && busRow == hr && busWrData == hd, "R5 hold while not ready",
            busWrData, hd);
      check(busReq, "R5 request kept", busReq, 1);
    end
    stall = 1'b0;

    // press and release during sweep
    startBtn = 1'b1;
    repeat (5) @(negedge clk);
    startBtn = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(busReq, "R9 sweep continues", busReq, 1);
    end

    // abort by reset
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busReq && !busWrite && busCol == 0 && busRow == 0, "R10 mid-sweep reset",
          {busReq, busWrite, busCol, busRow}, 0);

    // full frame
    startBtn = 1'b1;
    repeat (2) @(negedge clk);
    startBtn = 1'b0;
    @(negedge clk);
    check(busReq, "R3 second start", busReq, 1);
    while (busReq) @(negedge clk);
    check(refPh == 0 && busCol == 0 && busRow == 0 && !busWrite, "R8 frame end",
          {busWrite, busCol, busRow}, 0);
    repeat (10) begin
      @(negedge clk);
      check(!busReq && !busWrite, "R8 stays idle", {busReq, busWrite}, 0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule